// File: doc/BRIEF.md
# Clamping Integer Vector Lane ALU

This block is the integer execution slice of one lane in a SIMD shader datapath. Each issued instruction carries a 10-bit opcode, two 32-bit source operands, the lane's current destination value and a clamp modifier bit. The block returns the new destination value one clock later. It supports signed word add and subtract, signed half-word add and subtract, and a pack of two half-words into one word. The clamp bit chooses, per instruction, between two's-complement wrap and signed saturation.

Half-word arithmetic writes only the low half of the destination. The upper half of the incoming old destination passes through unchanged, so a lane can update one half of a register without a separate read-modify-write. An opcode outside the supported set does not corrupt the register. The old destination comes back unchanged, and an illegal flag is raised next to the valid strobe.

A two-state output machine controls the result port. `ST_IDLE` means no result is presented. `ST_HOLD` means a result computed from the previous cycle's inputs is on the port. The transitions are:
- `ST_IDLE -> ST_HOLD` when `in_valid` is high.
- `ST_HOLD -> ST_HOLD` when another instruction arrives back to back.
- `ST_HOLD -> ST_IDLE` when `in_valid` is low.
- Reset forces `ST_IDLE`.

Top module: `lane_int_alu`

## Requirements
- R1: Opcodes decode as follows:
  - 668 (0x29C): signed word add.
  - 669 (0x29D): signed word subtract.
  - 670 (0x29E): signed half-word add.
  - 671 (0x29F): signed half-word subtract.
  - 672 (0x2A0): half-word pack.
- R2: Word add without clamp returns (src0 + src1) mod 2^32.
- R3: Word subtract always computes src0 minus src1, and without clamp it wraps mod 2^32.
- R4: With clamp set, word add and subtract use a 33-bit signed intermediate. A value above 2^31-1 gives 0x7FFFFFFF, a value below -2^31 gives 0x80000000, and any other value is returned exactly.
- R5: Half-word add and subtract treat only bits 15:0 of each source as signed values. Source bits 31:16 have no effect. Without clamp, the low half wraps mod 2^16.
- R6: With clamp set, half-word add and subtract use a 17-bit signed intermediate. They give 0x7FFF above +32767 and 0x8000 below -32768.
- R7: Half-word operations place their 16-bit result in bits 15:0. Output bits 31:16 equal bits 31:16 of the old destination.
- R8: Pack returns src1[15:0] in bits 31:16 and src0[15:0] in bits 15:0. The clamp bit and the old destination have no effect.
- R9: Any opcode other than 668..672 returns the old destination unchanged with out_illegal high. Supported opcodes return out_illegal low.
- R10: out_valid is high exactly in the cycle after a cycle with in_valid high, and low otherwise. An active-low synchronous reset clears out_valid and out_illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction issue strobe |
| in_opcode | input | 10 | Operation code |
| in_src0 | input | 32 | First source operand |
| in_src1 | input | 32 | Second source operand |
| in_dst_old | input | 32 | Current destination value |
| in_clamp | input | 1 | Saturate instead of wrap |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 32 | New destination value |
| out_illegal | output | 1 | Opcode was not supported |

## Verification
Every cycle, the checker enforces the following:
- the one-cycle valid latency and the absence of spurious strobes;
- pass-through of the old destination with the illegal flag for unknown opcodes;
- preservation of the upper half for half-word operations;
- the exact pack layout;
- the rule that clamped word addition of two non-negative operands never yields a negative result.

The exact arithmetic has to be shown by the bench's behavioural model, which covers both saturation thresholds at each width, the wrapping cases at the same boundaries, source upper bits that must be ignored, and back-to-back versus gapped issue.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;

    localparam int OPC_W = 10;

    localparam logic [OPC_W-1:0] OPC_WADD = 10'h29C;
    localparam logic [OPC_W-1:0] OPC_WSUB = 10'h29D;
    localparam logic [OPC_W-1:0] OPC_HADD = 10'h29E;
    localparam logic [OPC_W-1:0] OPC_HSUB = 10'h29F;
    localparam logic [OPC_W-1:0] OPC_PACK = 10'h2A0;

    typedef enum logic [2:0] {
        K_WADD,
        K_WSUB,
        K_HADD,
        K_HSUB,
        K_PACK,
        K_BAD
    } op_kind_e;

    typedef enum logic {
        ST_IDLE,
        ST_HOLD
    } out_state_e;

endpackage

// File: rtl/lane_op_decode.sv
module lane_op_decode
    import lane_alu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output op_kind_e         kind
);

    always_comb begin
        unique case (opcode)
            OPC_WADD: kind = K_WADD;
            OPC_WSUB: kind = K_WSUB;
            OPC_HADD: kind = K_HADD;
            OPC_HSUB: kind = K_HSUB;
            OPC_PACK: kind = K_PACK;
            default:  kind = K_BAD;
        endcase
    end

endmodule

// File: rtl/lane_sat_addsub.sv
module lane_sat_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         clamp,
    output logic [W-1:0] y
);

    localparam int EW = W + 1;

    logic [EW-1:0] ext_a;
    logic [EW-1:0] ext_b;
    logic [EW-1:0] wide;
    logic          ovf;
    logic [W-1:0]  limit;

    always_comb begin
        ext_a = {a[W-1], a};
        ext_b = {b[W-1], b};
        wide  = sub ? (ext_a - ext_b) : (ext_a + ext_b);
        // the two top bits disagree only when the value leaves the W-bit range
        ovf   = wide[EW-1] ^ wide[W-1];
        limit = wide[EW-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        y     = (clamp && ovf) ? limit : wide[W-1:0];
    end

endmodule

// File: rtl/lane_int_alu.sv
module lane_int_alu
    import lane_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [9:0]        in_opcode,
    input  logic [DATA_W-1:0] in_src0,
    input  logic [DATA_W-1:0] in_src1,
    input  logic [DATA_W-1:0] in_dst_old,
    input  logic              in_clamp,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_illegal
);

    localparam int HALF_W = DATA_W / 2;

    op_kind_e          kind;
    out_state_e        state_q;
    out_state_e        state_d;
    logic [DATA_W-1:0] word_y;
    logic [HALF_W-1:0] half_y;
    logic [DATA_W-1:0] next_result;
    logic              next_illegal;

    lane_op_decode u_dec (
        .opcode (in_opcode),
        .kind   (kind)
    );

    lane_sat_addsub #(.W(DATA_W)) u_word (
        .a     (in_src0),
        .b     (in_src1),
        .sub   (kind == K_WSUB),
        .clamp (in_clamp),
        .y     (word_y)
    );

    lane_sat_addsub #(.W(HALF_W)) u_half (
        .a     (in_src0[HALF_W-1:0]),
        .b     (in_src1[HALF_W-1:0]),
        .sub   (kind == K_HSUB),
        .clamp (in_clamp),
        .y     (half_y)
    );

    always_comb begin
        next_illegal = 1'b0;
        unique case (kind)
            K_WADD, K_WSUB: next_result = word_y;
            K_HADD, K_HSUB: next_result = {in_dst_old[DATA_W-1:HALF_W], half_y};
            K_PACK:         next_result = {in_src1[HALF_W-1:0], in_src0[HALF_W-1:0]};
            default: begin
                next_result  = in_dst_old;
                next_illegal = 1'b1;
            end
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_HOLD : ST_IDLE;
            ST_HOLD: state_d = in_valid ? ST_HOLD : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_result  <= '0;
            out_illegal <= 1'b0;
        end else if (in_valid) begin
            out_result  <= next_result;
            out_illegal <= next_illegal;
        end
    end

    assign out_valid = (state_q == ST_HOLD);

endmodule

// File: rtl/lane_alu_chk.sv
module lane_alu_chk
    import lane_alu_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [9:0]  in_opcode,
    input logic [31:0] in_src0,
    input logic [31:0] in_src1,
    input logic [31:0] in_dst_old,
    input logic        in_clamp,
    input logic        out_valid,
    input logic [31:0] out_result,
    input logic        out_illegal
);

    logic legal_op;
    assign legal_op = (in_opcode >= OPC_WADD) && (in_opcode <= OPC_PACK);

    // R10
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R10
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R9
    illegal_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !legal_op) |=> (out_illegal && out_result == $past(in_dst_old)));

    // R9
    legal_flag_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && legal_op) |=> !out_illegal);

    // R7
    upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_opcode == OPC_HADD || in_opcode == OPC_HSUB))
        |=> out_result[31:16] == $past(in_dst_old[31:16]));

    // R8
    pack_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_opcode == OPC_PACK)
        |=> (out_result[31:16] == $past(in_src1[15:0]) && out_result[15:0] == $past(in_src0[15:0])));

    // R4
    no_pos_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_clamp && in_opcode == OPC_WADD && !in_src0[31] && !in_src1[31])
        |=> !out_result[31]);

endmodule

bind lane_int_alu lane_alu_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_opcode   (in_opcode),
    .in_src0     (in_src0),
    .in_src1     (in_src1),
    .in_dst_old  (in_dst_old),
    .in_clamp    (in_clamp),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_illegal (out_illegal)
);

// File: tb/tb_lane_int_alu.sv
module tb_lane_int_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [9:0]  in_opcode = '0;
    logic [31:0] in_src0 = '0;
    logic [31:0] in_src1 = '0;
    logic [31:0] in_dst_old = '0;
    logic        in_clamp = 1'b0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_illegal;

    int checks = 0;
    int failures = 0;

    bit          exp_valid = 1'b0;
    logic [31:0] exp_res = '0;
    bit          exp_ill = 1'b0;
    string       exp_tag = "R10";

    always #10 clk = ~clk;

    lane_int_alu dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_opcode   (in_opcode),
        .in_src0     (in_src0),
        .in_src1     (in_src1),
        .in_dst_old  (in_dst_old),
        .in_clamp    (in_clamp),
        .out_valid   (out_valid),
        .out_result  (out_result),
        .out_illegal (out_illegal)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic void model(input logic [9:0] op, input logic [31:0] s0, input logic [31:0] s1,
                                  input logic [31:0] old, input bit cl,
                                  output logic [31:0] r, output bit ill);
        longint a, b, t;
        ill = 1'b0;
        case (op)
            10'd668, 10'd669: begin
                a = longint'($signed(s0));
                b = longint'($signed(s1));
                t = (op == 10'd668) ? a + b : a - b;
                if (cl && t > 64'sd2147483647)       r = 32'h7FFF_FFFF;
                else if (cl && t < -64'sd2147483648) r = 32'h8000_0000;
                else                                 r = t[31:0];
            end
            10'd670, 10'd671: begin
                a = longint'($signed(s0[15:0]));
                b = longint'($signed(s1[15:0]));
                t = (op == 10'd670) ? a + b : a - b;
                if (cl && t > 32767)        r = {old[31:16], 16'h7FFF};
                else if (cl && t < -32768)  r = {old[31:16], 16'h8000};
                else                        r = {old[31:16], t[15:0]};
            end
            10'd672: r = {s1[15:0], s0[15:0]};
            default: begin
                r = old;
                ill = 1'b1;
            end
        endcase
    endfunction

    // compare the previous cycle's prediction, then drive the next instruction
    task automatic step(input string tag, input bit v, input logic [9:0] op, input logic [31:0] s0,
                        input logic [31:0] s1, input logic [31:0] old, input bit cl);
        logic [31:0] r;
        bit ill;
        @(negedge clk);
        check({exp_tag, " valid"}, {31'd0, out_valid}, {31'd0, exp_valid});
        if (exp_valid) begin
            check({exp_tag, " result"}, out_result, exp_res);
            check({exp_tag, " illegal"}, {31'd0, out_illegal}, {31'd0, exp_ill});
        end
        in_valid = v; in_opcode = op; in_src0 = s0; in_src1 = s1; in_dst_old = old; in_clamp = cl;
        model(op, s0, s1, old, cl, r, ill);
        exp_valid = v; exp_res = r; exp_ill = ill; exp_tag = tag;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset valid", {31'd0, out_valid}, 32'd0);
        check("R10 reset illegal", {31'd0, out_illegal}, 32'd0);
        // R1 R2 word add
        step("R1/R2 add small", 1, 10'd668, 32'd100, 32'd23, 32'hDEAD_BEEF, 0);
        step("R2 add wrap", 1, 10'd668, 32'h7FFF_FFFF, 32'd1, 32'h0, 0);
        step("R4 add clamp pos", 1, 10'd668, 32'h7FFF_FFFF, 32'd1, 32'h0, 1);
        step("R4 add clamp neg", 1, 10'd668, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0, 1);
        step("R4 add clamp inrange", 1, 10'd668, 32'hFFFF_FFF0, 32'd5, 32'h0, 1);
        // R3 subtract order and wrap
        step("R3 sub order", 1, 10'd669, 32'd5, 32'd7, 32'h0, 0);
        step("R3 sub wrap", 1, 10'd669, 32'h8000_0000, 32'd1, 32'h0, 0);
        step("R4 sub clamp neg", 1, 10'd669, 32'h8000_0000, 32'd1, 32'h0, 1);
        step("R4 sub clamp pos", 1, 10'd669, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0, 1);
        // R5 R6 R7 half-word
        step("R5/R7 hadd upper ignored", 1, 10'd670, 32'hAAAA_0003, 32'h5555_0004, 32'h1234_9999, 0);
        step("R5 hadd wrap", 1, 10'd670, 32'h0000_7FFF, 32'h0000_0001, 32'hCAFE_0000, 0);
        step("R6 hadd clamp pos", 1, 10'd670, 32'hFFFF_7FFF, 32'h0000_0001, 32'hCAFE_0000, 1);
        step("R6 hadd clamp neg", 1, 10'd670, 32'h0000_8000, 32'h0000_8000, 32'hBEEF_1111, 1);
        step("R5 hsub wrap", 1, 10'd671, 32'h0000_8000, 32'h0000_0001, 32'h0F0F_0000, 0);
        step("R6 hsub clamp neg", 1, 10'd671, 32'h0000_8000, 32'h0000_0001, 32'h0F0F_0000, 1);
        step("R6 hsub clamp pos", 1, 10'd671, 32'h0000_7FFF, 32'h0000_FFFF, 32'h7777_0000, 1);
        // R8 pack ignores clamp and old value
        step("R8 pack", 1, 10'd672, 32'h1111_ABCD, 32'h2222_1234, 32'hFFFF_FFFF, 1);
        step("R8 pack noclamp", 1, 10'd672, 32'h0000_8000, 32'hFFFF_7FFF, 32'h0, 0);
        // R9 unknown opcodes
        step("R9 below range", 1, 10'd667, 32'd1, 32'd2, 32'h5A5A_A5A5, 0);
        step("R9 above range", 1, 10'd673, 32'd1, 32'd2, 32'h0123_4567, 1);
        step("R9 zero", 1, 10'd0, 32'd1, 32'd2, 32'h89AB_CDEF, 0);
        step("R9 all ones", 1, 10'h3FF, 32'd1, 32'd2, 32'h0BAD_F00D, 0);
        // R10 gap then resume
        step("R10 gap", 0, 10'd668, 32'd1, 32'd1, 32'h0, 0);
        step("R10 gap2", 0, 10'd668, 32'd1, 32'd1, 32'h0, 0);
        step("R10 resume", 1, 10'd669, 32'd0, 32'd1, 32'h0, 1);
        for (int i = 0; i < 400; i++) begin
            logic [9:0] op;
            int sel;
            sel = $urandom_range(0, 6);
            op = (sel < 5) ? 10'(668 + sel) : ((sel == 5) ? 10'd1 : 10'd700);
            step("R1 random", bit'($urandom_range(0, 3) != 0), op, $urandom, $urandom, $urandom,
                 bit'($urandom_range(0, 1)));
        end
        step("R10 drain", 0, 10'd0, 32'd0, 32'd0, 32'd0, 0);
        step("R10 drain2", 0, 10'd0, 32'd0, 32'd0, 32'd0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule